// File: doc/BRIEF.md
# CPU-Cycle Down-Counting Interrupt Timer

This block is an interrupt timer that counts down once for each CPU cycle. It sits on the write side of a CPU bus. The processor builds a 16-bit start value one nibble at a time, copies that value into the working counter with a separate write, and arms the timer through a control write. That control write also chooses how many low-order counter bits are active: 4, 8, 12 or 16.

When armed, the timer decrements the active portion of the counter on each CPU cycle. When that portion reaches zero, the timer pulls its active-low interrupt line low and disarms itself. The line stays low until software acknowledges it with either of the two control writes. Counter bits above the chosen width are left untouched, so one loaded value can be reused at several widths.

The CPU cycle is presented as a single-cycle enable, `cpu_cycle`, on the fast system clock. Writes are single-cycle strobes on the same clock.

Top module: `cyc_irq_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `irq_n` is 1, the timer is disarmed, the start value and counter are zero, and the width is 16 bits. Arming the timer with no load then raises no interrupt.
- R2: A write whose address has bits 15:12 equal to 0xE stores `wr_data[3:0]` into one nibble of the start value. Address bits 1:0 pick the nibble: 0 for bits 3:0, 1 for 7:4, 2 for 11:8, 3 for 15:12. Address bits 11:2 and data bits 7:4 are ignored.
- R3: A write with address bits 15:12 = 0xF and bits 1:0 = 0 copies the start value into the counter and returns `irq_n` to 1.
- R4: A write with address bits 15:12 = 0xF and bits 1:0 = 1 sets the armed state from `wr_data[0]`, selects the width, and returns `irq_n` to 1.
- R5: On that control write, the width is chosen by priority. `wr_data[3]` set gives 4 bits. Otherwise `wr_data[2]` set gives 8 bits. Otherwise `wr_data[1]` set gives 12 bits. Otherwise the width is 16 bits.
- R6: In a cycle with `cpu_cycle` high, the counter decrements by one if the timer is armed and the active bits are nonzero. With a nonzero active value N, `irq_n` falls at the edge of the N-th counted CPU cycle.
- R7: In the cycle where the active bits reach zero, `irq_n` goes to 0 and the timer disarms, so no further counting happens until it is armed again.
- R8: If the active bits are already zero, a CPU cycle neither decrements the counter nor raises the interrupt.
- R9: Decrementing never changes counter bits above the selected width.
- R10: Once low, `irq_n` stays low through CPU cycles and start-value writes until a write as in R3 or R4 occurs.
- R11: A write as in R3 or R4 in the same clock as `cpu_cycle` takes priority, and that CPU cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cycle | input | 1 | One-clock pulse per CPU cycle |
| wr_en | input | 1 | CPU write strobe, one clock per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that every write lasts exactly one clock and that `cpu_cycle` is a clean one-clock enable. They also assume that an interrupt can only be raised in a cycle with no acknowledging write, which R11 guarantees. The stimulus drives all inputs at the falling edge, keeps each write to a single clock, and mixes decoded addresses, aliases of those addresses and undecoded addresses with random data. It also places control writes on the same clock as CPU cycles, so the priority rule is exercised rather than avoided.

// File: rtl/cyc_timer_pkg.sv
// Package: shared types and decode constants for the CPU-cycle timer.
// Assumes a 16-bit counter made of four 4-bit nibbles.
package cyc_timer_pkg;

    // Active counter width, ordered so that value + 1 = active nibble count.
    typedef enum logic [1:0] {
        WID_4  = 2'd0,
        WID_8  = 2'd1,
        WID_12 = 2'd2,
        WID_16 = 2'd3
    } wid_e;

    localparam logic [3:0] PAGE_RLD = 4'hE;  // start-value nibble writes
    localparam logic [3:0] PAGE_CTL = 4'hF;  // load / control writes

    // Priority pick of the active width from the control nibble.
    function automatic wid_e pick_width(input logic [3:0] f);
        if (f[3])      return WID_4;
        else if (f[2]) return WID_8;
        else if (f[1]) return WID_12;
        else           return WID_16;
    endfunction

endpackage

// File: rtl/cyc_timer_dec.sv
// Module: write decoder. Turns a one-clock CPU write into one-hot strobes.
// Assumes wr_en lasts one clock per write. Only the page bits and the low
// select bits are decoded, so the other address bits alias.
module cyc_timer_dec
    import cyc_timer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              rld_we,
    output logic [SEL_W-1:0]  rld_sel,
    output logic              load_we,
    output logic              ctrl_we
);
    logic [3:0] page;

    // Purpose: split the address into page and sub-select fields.
    always_comb begin
        page    = wr_addr[ADDR_W-1 -: 4];
        rld_sel = wr_addr[SEL_W-1:0];
    end

    // Purpose: raise the strobe that matches the decoded address.
    always_comb begin
        rld_we  = wr_en && (page == PAGE_RLD);
        load_we = wr_en && (page == PAGE_CTL) && (wr_addr[1:0] == 2'd0);
        ctrl_we = wr_en && (page == PAGE_CTL) && (wr_addr[1:0] == 2'd1);
    end

endmodule

// File: rtl/cyc_timer_reload.sv
// Module: start-value register, written one nibble per write.
// Assumes rld_sel is in range (CNT_W / NIB_W nibbles).
module cyc_timer_reload #(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4,
    localparam int NIBS  = CNT_W / NIB_W,
    localparam int SEL_W = $clog2(NIBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_we,
    input  logic [SEL_W-1:0] rld_sel,
    input  logic [NIB_W-1:0] nib_in,
    output logic [CNT_W-1:0] rld_val
);
    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        logic [NIB_W-1:0] nib_q;

        // Purpose: hold one nibble of the start value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                nib_q <= '0;
            else if (rld_we && (rld_sel == SEL_W'(n)))
                nib_q <= nib_in;
        end

        assign rld_val[n*NIB_W +: NIB_W] = nib_q;
    end

endmodule

// File: rtl/cyc_timer_core.sv
// Module: counter, arm bit and width select. Decrements the active low
// bits once per CPU cycle and produces a one-clock fire pulse when they
// reach zero. Assumes four nibbles (one per wid_e value).
module cyc_timer_core
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4,
    localparam int NIBS = CNT_W / NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cycle,
    input  logic             load_we,
    input  logic             ctrl_we,
    input  logic [3:0]       ctl_nib,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic [CNT_W-1:0] mask_w,
    output logic             fire
);
    wid_e             wid_q;
    logic [CNT_W-1:0] act_bits;
    logic [CNT_W-1:0] cnt_dec;
    logic             count_ok;

    // Purpose: build the active-bit mask, one nibble per generate step.
    for (genvar n = 0; n < NIBS; n++) begin : g_mask
        assign mask_w[n*NIB_W +: NIB_W] = {NIB_W{(32'(n) <= 32'(wid_q))}};
    end

    // Purpose: find the count condition and the next counter value.
    always_comb begin
        act_bits = cnt_q & mask_w;
        count_ok = cpu_cycle && en_q && !load_we && !ctrl_we && (act_bits != '0);
        cnt_dec  = (cnt_q & ~mask_w) | ((cnt_q - CNT_W'(1)) & mask_w);
        fire     = count_ok && (act_bits == CNT_W'(1));
    end

    // Purpose: update counter, arm bit and width; writes beat counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            wid_q <= WID_16;
        end else if (load_we) begin
            cnt_q <= rld_val;
        end else if (ctrl_we) begin
            en_q  <= ctl_nib[0];
            wid_q <= pick_width(ctl_nib);
        end else if (count_ok) begin
            cnt_q <= cnt_dec;
            if (fire)
                en_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cyc_timer_irq.sv
// Module: interrupt latch. Set by the fire pulse, cleared by an acknowledge.
// Assumes fire and ack never coincide (the core suppresses fire on writes).
module cyc_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    output logic irq_n
);
    logic pend_q;

    // Purpose: hold the pending request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (fire)
            pend_q <= 1'b1;
        else if (ack)
            pend_q <= 1'b0;
    end

    assign irq_n = !pend_q;

endmodule

// File: rtl/cyc_irq_timer.sv
// Module: top of the CPU-cycle interrupt timer. Joins the decoder, the
// start-value register, the counter core and the interrupt latch.
// Assumes one-clock write strobes and a one-clock cpu_cycle enable.
module cyc_irq_timer #(
    parameter int CNT_W  = 16,
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int NIBS  = CNT_W / NIB_W,
    localparam int SEL_W = $clog2(NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cycle,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_n
);
    logic             rld_we;
    logic [SEL_W-1:0] rld_sel;
    logic             load_we;
    logic             ctrl_we;
    logic [CNT_W-1:0] rld_val;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic [CNT_W-1:0] mask_w;
    logic             fire;

    cyc_timer_dec #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) dec_i (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rld_we  (rld_we),
        .rld_sel (rld_sel),
        .load_we (load_we),
        .ctrl_we (ctrl_we)
    );

    cyc_timer_reload #(.CNT_W(CNT_W), .NIB_W(NIB_W)) rld_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rld_we  (rld_we),
        .rld_sel (rld_sel),
        .nib_in  (wr_data[NIB_W-1:0]),
        .rld_val (rld_val)
    );

    cyc_timer_core #(.CNT_W(CNT_W), .NIB_W(NIB_W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_cycle (cpu_cycle),
        .load_we   (load_we),
        .ctrl_we   (ctrl_we),
        .ctl_nib   (wr_data[3:0]),
        .rld_val   (rld_val),
        .cnt_q     (cnt_q),
        .en_q      (en_q),
        .mask_w    (mask_w),
        .fire      (fire)
    );

    cyc_timer_irq irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .ack   (load_we || ctrl_we),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
// Module: assertion checker for cyc_irq_timer, attached with bind.
// Assumes one-clock write strobes; decodes acknowledges from the ports.
module cyc_irq_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_cycle,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              en,
    input logic [CNT_W-1:0]  mask
);
    logic ack_wr;
    assign ack_wr = wr_en && (wr_addr[ADDR_W-1 -: 4] == 4'hF) && !wr_addr[1];

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (irq_n && !en));

    // R3 R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> irq_n);

    // R7
    fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> (!en && ((cnt & mask) == '0)));

    // R8
    zero_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && ((cnt & mask) == '0)) |=> ($stable(cnt) && ($stable(irq_n) || !irq_n)));

    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cycle && en && !ack_wr && ((cnt & mask) != '0)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R9
    upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> ((cnt & ~mask) == ($past(cnt) & ~$past(mask))));

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ack_wr) |=> !irq_n);

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && cpu_cycle) |=> irq_n);

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_cycle (cpu_cycle),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_n     (irq_n),
    .cnt       (cnt_q),
    .en        (en_q),
    .mask      (mask_w)
);

// File: tb/cyc_irq_timer_tb_top.sv
`timescale 1ns/1ps
module cyc_irq_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cycle = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    auto_chk = 0;
    string cur_req = "R1";

    // bench model state
    logic [15:0] m_rld, m_cnt, m_mask;
    logic        m_en, m_irq;

    always #2.5 clk = ~clk;

    cyc_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_cycle(cpu_cycle), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n)
    );

    function automatic logic [15:0] width_mask(input logic [7:0] d);
        if (d[3])      return 16'h000F;
        else if (d[2]) return 16'h00FF;
        else if (d[1]) return 16'h0FFF;
        else           return 16'hFFFF;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rld = '0; m_cnt = '0; m_mask = 16'hFFFF; m_en = 0; m_irq = 0;
    endtask

    // One clock: drive at falling edge, update model at rising edge.
    task automatic step(input bit we, input logic [15:0] a, input logic [7:0] d, input bit tk);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; cpu_cycle = tk;
        @(posedge clk);
        if (we && a[15:12] == 4'hE)
            m_rld[a[1:0]*4 +: 4] = d[3:0];
        if (we && a[15:12] == 4'hF && a[1:0] == 2'd0) begin
            m_cnt = m_rld; m_irq = 0;
        end else if (we && a[15:12] == 4'hF && a[1:0] == 2'd1) begin
            m_en = d[0]; m_mask = width_mask(d); m_irq = 0;
        end else if (tk && m_en && (m_cnt & m_mask) != 0) begin
            m_cnt = m_cnt - 16'd1;
            if ((m_cnt & m_mask) == 0) begin m_en = 0; m_irq = 1; end
        end
        #1;
        if (auto_chk) chk(cur_req, irq_n, !m_irq);
        @(negedge clk);
        wr_en = 0; cpu_cycle = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        step(1, a, d, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 16'h0000, 8'h00, 1);
    endtask

    task automatic load16(input logic [15:0] v);
        for (int k = 0; k < 4; k++) wr(16'hE000 | 16'(k), {4'hA, v[k*4 +: 4]});
        wr(16'hF000, 8'h00);
    endtask

    // Expect irq_n high after n-1 counted cycles and low after n.
    task automatic fire_after(input string req, input int n);
        ticks(n - 1);
        chk(req, irq_n, 1'b1);
        ticks(1);
        chk(req, irq_n, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: run did not finish, irq_n=%b expected completion", irq_n);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        cur_req = "R1";
        chk("R1", irq_n, 1'b1);
        wr(16'hF001, 8'h01);
        ticks(20);
        chk("R1", irq_n, 1'b1);

        // R8: zero counter, armed, cycles raise nothing
        ticks(5);
        chk("R8", irq_n, 1'b1);

        // R2 R3 R6 R7: load 5 with junk in upper data bits, 16-bit width
        wr(16'hE000, 8'hF5);
        wr(16'hE001, 8'hF0);
        wr(16'hE002, 8'h30);
        wr(16'hE003, 8'h70);
        wr(16'hF000, 8'h00);
        wr(16'hF001, 8'h01);
        fire_after("R6", 5);

        // R10: stays low through cycles and start-value writes
        ticks(10);
        wr(16'hE001, 8'h00);
        chk("R10", irq_n, 1'b0);

        // R3: load write acknowledges
        wr(16'hF000, 8'h00);
        chk("R3", irq_n, 1'b1);
        // R7: disarmed after firing, reload alone does not restart
        ticks(30);
        chk("R7", irq_n, 1'b1);

        // R4: control write acknowledges
        wr(16'hF001, 8'h01);
        fire_after("R7", 5);
        wr(16'hF001, 8'h00);
        chk("R4", irq_n, 1'b1);

        // R5: widths from a start value of 0x0123
        load16(16'h0123);
        wr(16'hF001, 8'h05);
        fire_after("R5", 16'h23);
        load16(16'h0123);
        wr(16'hF001, 8'h0F);
        fire_after("R5", 3);
        load16(16'h0123);
        wr(16'hF001, 8'h03);
        fire_after("R5", 16'h123);

        // R9: upper bits survive a 4-bit run, then count at 16 bits
        load16(16'h1203);
        wr(16'hF001, 8'h09);
        fire_after("R9", 3);
        wr(16'hF001, 8'h01);
        fire_after("R9", 16'h1200);

        // R11: control write on the same clock as a cycle wins
        load16(16'h0003);
        wr(16'hF001, 8'h01);
        step(1, 16'hF001, 8'h01, 1);
        fire_after("R11", 3);

        // R2: aliased address bits decode, undecoded pages are ignored
        wr(16'hE00C, 8'h02);
        wr(16'hE3F5, 8'h00);
        wr(16'hEFFE, 8'h00);
        wr(16'hEA0B, 8'h00);
        wr(16'hD000, 8'h0F);
        wr(16'hF002, 8'h0F);
        wr(16'hF000, 8'h00);
        wr(16'hF001, 8'h01);
        fire_after("R2", 2);

        // Random phase against the bench model
        void'($urandom(32'd20240511));
        cur_req = "R6 R7 R10 R11";
        auto_chk = 1;
        for (int i = 0; i < 20000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            logic [7:0] d = 8'($urandom());
            bit tk = ($urandom_range(0, 3) != 0);
            if (r < 70)
                step(0, 16'($urandom()), d, tk);
            else if (r < 82)
                step(1, {4'hE, 10'($urandom()), 2'($urandom())}, d, tk);
            else if (r < 88)
                step(1, {4'hF, 10'($urandom()), 2'b00}, d, tk);
            else if (r < 95)
                step(1, {4'hF, 10'($urandom()), 2'b01}, {d[7:4], d[3:1], 1'b1}, tk);
            else
                step(1, {4'($urandom_range(0, 13)), 12'($urandom())}, d, tk);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule